// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, every cycle, which hardware thread of a multithreaded core is allowed to fetch. It looks at a per-thread active mask, a per-thread pipeline status code and two per-thread occupancy counts, one for the instruction queue and one for the load/store queue. From these it produces a thread number and a valid flag. The selection itself is combinational, so the fetch unit sees the choice in the same cycle as its inputs.

Four selection policies are available through a two-bit select. A single-thread policy looks only at the lowest-numbered active thread. A rotating policy walks an ordered list of threads held inside the block. When the fetch unit consumes a pick, the winner moves to the back of that list. Two occupancy policies pick the eligible thread that reports the fewest queued entries. A separate removal port drops a thread from the rotating list. Reset restores the list to ascending thread order.

Top module: `fetch_thread_picker`

## Requirements
- R1: A thread is eligible only when its active bit is set and its 3-bit status is 0 (running), 1 (idle) or 5 (instruction return complete). Statuses 2, 3, 4, 6 and 7 never win, and no thread is ever chosen without its active bit.
- R2: With policy 1 (rotating), the output is the thread in the first list position, counted from the front, whose thread is eligible.
- R3: With policy 1, when `fetch_go` is high and a thread is chosen, the list is updated at the next clock edge. The chosen entry goes to the last occupied position, and the entries behind it each move one place forward. Nothing moves when `fetch_go` is low, the policy differs, or no thread is chosen.
- R4: With policy 2, the output is the eligible thread with the smallest `iq_occ` count. On equal counts the lower thread number wins.
- R5: With policy 3, the same rule as R4 is applied to `lsq_occ`.
- R6: When no thread qualifies under the active policy, `sel_valid` is 0 and `sel_tid` is all ones.
- R7: A pulse on `drop_en` removes thread `drop_tid` from the rotating list. The later entries close up, so the occupied positions stay packed at the front. Removing a thread that is not in the list changes nothing.
- R8: After reset the list holds every thread once, in ascending order, with thread 0 at the front.
- R9: With policy 0 (single thread), only the lowest-numbered active thread is considered. If that thread is not eligible, the output is invalid, even when higher threads are eligible.
- R10: When a pick with move-to-back and a removal fall in the same cycle, both are applied, the move first. If both name the same thread, that thread simply leaves the list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_mask | input | N | Per-thread active bit |
| thr_status | input | 3*N | Per-thread status code, thread t in bits [3t+2:3t] |
| iq_occ | input | CNT_W*N | Per-thread instruction-queue occupancy |
| lsq_occ | input | CNT_W*N | Per-thread load/store-queue occupancy |
| policy | input | 2 | 0 single, 1 rotating, 2 instruction-queue, 3 load/store-queue |
| fetch_go | input | 1 | Current pick is consumed (advances the rotating list) |
| drop_en | input | 1 | Remove a thread from the rotating list |
| drop_tid | input | TID_W | Thread to remove |
| sel_valid | output | 1 | A thread was chosen |
| sel_tid | output | TID_W | Chosen thread, all ones when none |

## Verification
The delicate case is a consumed rotating pick landing in the same cycle as a removal. Both rewrite the ordered list: one rotates an entry to the back, and the other closes a gap. The bench drives `fetch_go` and `drop_en` together in two directed forms, once naming the thread being picked and once naming a different one. It also mixes them freely under random stimulus. It judges the result through the order of later rotating picks, which it compares against its own list model.

// File: rtl/fsel_pkg.sv
`timescale 1ns/1ps
package fsel_pkg;

  localparam int unsigned STAT_W = 3;

  typedef enum logic [STAT_W-1:0] {
    ST_RUN        = 3'd0,
    ST_IDLE       = 3'd1,
    ST_SQUASH     = 3'd2,
    ST_BLOCK      = 3'd3,
    ST_MISS_WAIT  = 3'd4,
    ST_MISS_DONE  = 3'd5,
    ST_XLATE_WAIT = 3'd6,
    ST_TRAP       = 3'd7
  } thr_state_e;

  typedef enum logic [1:0] {
    POL_SINGLE = 2'd0,
    POL_RR     = 2'd1,
    POL_IQ     = 2'd2,
    POL_LSQ    = 2'd3
  } pick_pol_e;

  function automatic logic may_fetch(input logic [STAT_W-1:0] s);
    return (s == ST_RUN) || (s == ST_IDLE) || (s == ST_MISS_DONE);
  endfunction

endpackage

// File: rtl/fsel_elig.sv
`timescale 1ns/1ps
module fsel_elig #(
  parameter int unsigned N     = 4,
  parameter int unsigned TID_W = 2
) (
  input  logic [N-1:0]                   act_mask,
  input  logic [N*fsel_pkg::STAT_W-1:0]  thr_status,
  output logic [N-1:0]                   elig,
  output logic                           st_valid,
  output logic [TID_W-1:0]               st_tid
);
  localparam int unsigned SW = fsel_pkg::STAT_W;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_thr
      assign elig[g] = act_mask[g] && fsel_pkg::may_fetch(thr_status[g*SW +: SW]);
    end
  endgenerate

  // single-thread mode: only the lowest active thread counts
  logic             first_found;
  logic [TID_W-1:0] first_tid;

  always_comb begin
    first_found = 1'b0;
    first_tid   = '0;
    for (int i = 0; i < N; i++) begin
      if (!first_found && act_mask[i]) begin
        first_found = 1'b1;
        first_tid   = TID_W'(i);
      end
    end
    st_valid = first_found && elig[first_tid];
    st_tid   = first_tid;
  end

endmodule

// File: rtl/fsel_min_pick.sv
`timescale 1ns/1ps
module fsel_min_pick #(
  parameter int unsigned N     = 4,
  parameter int unsigned CNT_W = 6,
  parameter int unsigned TID_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         elig,
  input  logic [N*CNT_W-1:0]   occ,
  output logic                 win_valid,
  output logic [TID_W-1:0]     win_tid
);
  logic [CNT_W-1:0] cnt [N];

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_slice
      assign cnt[g] = occ[g*CNT_W +: CNT_W];
    end
  endgenerate

  logic [CNT_W-1:0] best_cnt;

  // strict less-than keeps the lower index on ties
  always_comb begin
    win_valid = 1'b0;
    win_tid   = '0;
    best_cnt  = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!win_valid || (cnt[i] < best_cnt))) begin
        win_valid = 1'b1;
        win_tid   = TID_W'(i);
        best_cnt  = cnt[i];
      end
    end
  end

  // independent order check: nobody eligible beats the winner
  logic min_broken;
  always_comb begin
    min_broken = 1'b0;
    for (int j = 0; j < N; j++) begin
      if (win_valid && elig[j] &&
          ((cnt[j] < cnt[win_tid]) ||
           ((cnt[j] == cnt[win_tid]) && (TID_W'(j) < win_tid))))
        min_broken = 1'b1;
    end
  end

  assert_min_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !min_broken);

  assert_win_elig_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> elig[win_tid]);

endmodule

// File: rtl/fsel_order_list.sv
`timescale 1ns/1ps
module fsel_order_list #(
  parameter int unsigned N     = 4,
  parameter int unsigned TID_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      elig,
  input  logic              upd_en,
  input  logic              drop_en,
  input  logic [TID_W-1:0]  drop_tid,
  output logic              rr_valid,
  output logic [TID_W-1:0]  rr_tid
);
  localparam int unsigned CW = $clog2(N + 1);

  logic [TID_W-1:0] ids_q  [N];
  logic [TID_W-1:0] ids_d  [N];
  logic [N-1:0]     vld_q, vld_d;
  logic [TID_W-1:0] ids_sh [N];
  logic [N-1:0]     vld_sh;
  logic [TID_W-1:0] mv_ids [N];
  logic [TID_W-1:0] mv_sh  [N];
  logic [TID_W-1:0] rr_pos;
  logic [CW-1:0]    vcount;
  logic [TID_W-1:0] last_pos;
  logic             move_do;
  logic             hit;
  logic [TID_W-1:0] hit_pos;
  logic             list_we;

  // one-place-forward views of the list
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_shift
      if (g < N - 1) begin : g_mid
        assign ids_sh[g] = ids_q[g+1];
        assign vld_sh[g] = vld_q[g+1];
        assign mv_sh[g]  = mv_ids[g+1];
      end else begin : g_end
        assign ids_sh[g] = '0;
        assign vld_sh[g] = 1'b0;
        assign mv_sh[g]  = '0;
      end
    end
  endgenerate

  // scan from the front for the first eligible entry
  always_comb begin
    rr_valid = 1'b0;
    rr_pos   = '0;
    rr_tid   = '1;
    for (int i = 0; i < N; i++) begin
      if (!rr_valid && vld_q[i] && elig[ids_q[i]]) begin
        rr_valid = 1'b1;
        rr_pos   = TID_W'(i);
        rr_tid   = ids_q[i];
      end
    end
  end

  always_comb begin
    vcount = '0;
    for (int i = 0; i < N; i++) vcount = vcount + CW'(vld_q[i]);
    last_pos = TID_W'(vcount - 1'b1);
  end

  // stage 1: move the chosen entry to the back
  assign move_do = upd_en && rr_valid;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      mv_ids[i] = ids_q[i];
      if (move_do) begin
        if ((TID_W'(i) >= rr_pos) && (TID_W'(i) < last_pos))
          mv_ids[i] = ids_sh[i];
        else if (TID_W'(i) == last_pos)
          mv_ids[i] = rr_tid;
      end
    end
  end

  // stage 2: remove a thread and close the gap
  always_comb begin
    hit     = 1'b0;
    hit_pos = '0;
    for (int i = 0; i < N; i++) begin
      if (!hit && vld_q[i] && (mv_ids[i] == drop_tid)) begin
        hit     = 1'b1;
        hit_pos = TID_W'(i);
      end
    end
  end

  always_comb begin
    vld_d = vld_q;
    for (int i = 0; i < N; i++) begin
      ids_d[i] = mv_ids[i];
      if (drop_en && hit && (TID_W'(i) >= hit_pos)) begin
        ids_d[i] = mv_sh[i];
        vld_d[i] = vld_sh[i];
      end
    end
  end

  assign list_we = move_do || (drop_en && hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) ids_q[i] <= TID_W'(i);
      vld_q <= '1;
    end else if (list_we) begin
      ids_q <= ids_d;
      vld_q <= vld_d;
    end
  end

  // checking aids
  logic             armed_q;
  logic [TID_W-1:0] last_id;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assign last_id = ids_q[last_pos];

  assert_packed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((vld_q & (vld_q + 1'b1)) == '0));

  assert_never_grows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (vcount <= $past(vcount)));

  assert_moved_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (move_do && !drop_en) |=> (last_id == $past(rr_tid)));

endmodule

// File: rtl/fetch_thread_picker.sv
`timescale 1ns/1ps
module fetch_thread_picker #(
  parameter  int unsigned N     = 4,
  parameter  int unsigned CNT_W = 6,
  localparam int unsigned TID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N-1:0]                   act_mask,
  input  logic [N*fsel_pkg::STAT_W-1:0]  thr_status,
  input  logic [N*CNT_W-1:0]             iq_occ,
  input  logic [N*CNT_W-1:0]             lsq_occ,
  input  logic [1:0]                     policy,
  input  logic                           fetch_go,
  input  logic                           drop_en,
  input  logic [TID_W-1:0]               drop_tid,
  output logic                           sel_valid,
  output logic [TID_W-1:0]               sel_tid
);
  import fsel_pkg::*;

  logic [N-1:0]       elig;
  logic               st_valid;
  logic [TID_W-1:0]   st_tid;
  logic               rr_valid;
  logic [TID_W-1:0]   rr_tid;
  logic [N*CNT_W-1:0] occ_src  [2];
  logic               mp_valid [2];
  logic [TID_W-1:0]   mp_tid   [2];
  logic               rr_upd;
  logic               pick_v;
  logic [TID_W-1:0]   pick_t;

  fsel_elig #(.N(N), .TID_W(TID_W)) u_elig (
    .act_mask   (act_mask),
    .thr_status (thr_status),
    .elig       (elig),
    .st_valid   (st_valid),
    .st_tid     (st_tid)
  );

  assign rr_upd = fetch_go && (pick_pol_e'(policy) == POL_RR);

  fsel_order_list #(.N(N), .TID_W(TID_W)) u_list (
    .clk      (clk),
    .rst_n    (rst_n),
    .elig     (elig),
    .upd_en   (rr_upd),
    .drop_en  (drop_en),
    .drop_tid (drop_tid),
    .rr_valid (rr_valid),
    .rr_tid   (rr_tid)
  );

  assign occ_src[0] = iq_occ;
  assign occ_src[1] = lsq_occ;

  genvar k;
  generate
    for (k = 0; k < 2; k++) begin : g_occ
      fsel_min_pick #(.N(N), .CNT_W(CNT_W), .TID_W(TID_W)) u_min (
        .clk       (clk),
        .rst_n     (rst_n),
        .elig      (elig),
        .occ       (occ_src[k]),
        .win_valid (mp_valid[k]),
        .win_tid   (mp_tid[k])
      );
    end
  endgenerate

  always_comb begin
    case (pick_pol_e'(policy))
      POL_SINGLE: begin pick_v = st_valid;    pick_t = st_tid;    end
      POL_RR:     begin pick_v = rr_valid;    pick_t = rr_tid;    end
      POL_IQ:     begin pick_v = mp_valid[0]; pick_t = mp_tid[0]; end
      default:    begin pick_v = mp_valid[1]; pick_t = mp_tid[1]; end
    endcase
    sel_valid = pick_v;
    sel_tid   = pick_v ? pick_t : '1;
  end

  assert_sel_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> elig[sel_tid]);

  assert_none_eligible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == '0) |-> !sel_valid);

  assert_single_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pick_pol_e'(policy) == POL_SINGLE) && sel_valid) |->
      ((act_mask & ((N'(1) << sel_tid) - N'(1))) == '0));

endmodule

// File: tb/fetch_thread_picker_bench.sv
`timescale 1ns/1ps
module fetch_thread_picker_bench;
  localparam int N = 4, CNT_W = 6, TID_W = 2, SW = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                rst_n;
  logic [N-1:0]        act_mask;
  logic [N*SW-1:0]     thr_status;
  logic [N*CNT_W-1:0]  iq_occ, lsq_occ;
  logic [1:0]          policy;
  logic                fetch_go, drop_en;
  logic [TID_W-1:0]    drop_tid;
  logic                sel_valid;
  logic [TID_W-1:0]    sel_tid;

  fetch_thread_picker #(.N(N), .CNT_W(CNT_W)) u_fetch_thread_picker (
    .clk(clk), .rst_n(rst_n), .act_mask(act_mask), .thr_status(thr_status),
    .iq_occ(iq_occ), .lsq_occ(lsq_occ), .policy(policy), .fetch_go(fetch_go),
    .drop_en(drop_en), .drop_tid(drop_tid), .sel_valid(sel_valid), .sel_tid(sel_tid)
  );

  int vecs = 0, fails = 0;
  int mlist [N];
  int mcnt;
  int st [N], iq [N], lsq [N];

  function automatic bit elig_f(int t);
    return act_mask[t] && (st[t] == 0 || st[t] == 1 || st[t] == 5);
  endfunction

  function automatic void expect_sel(output bit v, output int t);
    v = 0; t = N - 1;
    case (policy)
      2'd0: for (int i = 0; i < N; i++) begin
              if (act_mask[i]) begin
                if (elig_f(i)) begin v = 1; t = i; end
                break;
              end
            end
      2'd1: for (int p = 0; p < mcnt; p++) begin
              if (elig_f(mlist[p])) begin v = 1; t = mlist[p]; break; end
            end
      default: begin
        int best = 0;
        for (int i = 0; i < N; i++) begin
          int c = (policy == 2'd2) ? iq[i] : lsq[i];
          if (elig_f(i) && (!v || c < best)) begin v = 1; t = i; best = c; end
        end
      end
    endcase
  endfunction

  task automatic pack();
    for (int t = 0; t < N; t++) begin
      thr_status[t*SW +: SW]     = SW'(st[t]);
      iq_occ[t*CNT_W +: CNT_W]   = CNT_W'(iq[t]);
      lsq_occ[t*CNT_W +: CNT_W]  = CNT_W'(lsq[t]);
    end
  endtask

  task automatic model_edge();
    bit v; int t;
    expect_sel(v, t);
    if (fetch_go && policy == 2'd1 && v) begin
      int p = 0;
      for (int q = 0; q < mcnt; q++) if (mlist[q] == t) p = q;
      for (int q = p; q < mcnt - 1; q++) mlist[q] = mlist[q+1];
      mlist[mcnt-1] = t;
    end
    if (drop_en) begin
      int p = -1;
      for (int q = 0; q < mcnt; q++) if (p < 0 && mlist[q] == int'(drop_tid)) p = q;
      if (p >= 0) begin
        for (int q = p; q < mcnt - 1; q++) mlist[q] = mlist[q+1];
        mcnt = mcnt - 1;
      end
    end
  endtask

  task automatic check_now(string tag);
    bit v; int t; int et;
    expect_sel(v, t);
    et = v ? t : (1 << TID_W) - 1;
    vecs++;
    if (sel_valid !== v || int'(sel_tid) != et) begin
      fails++;
      $display("FAIL %s: valid=%0d tid=%0d, expected valid=%0d tid=%0d",
               tag, sel_valid, sel_tid, v, et);
    end
  endtask

  // entered at a falling edge, returns at the next falling edge
  task automatic step(string tag);
    pack();
    #1;
    check_now(tag);
    model_edge();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) mlist[i] = i;
    mcnt = N;
  endtask

  task automatic all_state(logic [N-1:0] a, int s);
    act_mask = a; fetch_go = 0; drop_en = 0; drop_tid = '0;
    for (int i = 0; i < N; i++) begin st[i] = s; iq[i] = 0; lsq[i] = 0; end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4021));
    rst_n = 1'b0; policy = 2'd1;
    all_state('1, 0);
    pack();
    @(negedge clk);
    do_reset();

    // R8: list rebuilt ascending, rotation walks it in order
    step("R8");
    fetch_go = 1;
    for (int i = 0; i < 5; i++) step("R8 R3");
    fetch_go = 0;
    step("R3");

    // R1: only running, idle, return-complete statuses win
    st[0] = 2; st[1] = 5; st[2] = 3; st[3] = 4;
    step("R1");
    st[1] = 1; step("R1");
    act_mask = 4'b1101; step("R1");
    st[3] = 7; st[0] = 6; act_mask = '1; st[1] = 3; step("R1");

    // R6: nothing eligible under any policy
    all_state('1, 3);
    for (int p = 0; p < 4; p++) begin policy = 2'(p); step("R6"); end
    all_state('0, 0);
    policy = 2'd2; step("R6");

    // R7: removal closes the gap, repeated removal is a no-op
    do_reset();
    all_state('1, 0); policy = 2'd1;
    drop_en = 1; drop_tid = 2'd2; step("R7");
    drop_en = 0; fetch_go = 1;
    for (int i = 0; i < 4; i++) step("R7");
    fetch_go = 0; drop_en = 1; drop_tid = 2'd2; step("R7");
    drop_en = 0;
    for (int i = 0; i < 3; i++) step("R7");

    // R10: pick and removal together
    do_reset();
    all_state('1, 0); policy = 2'd1;
    fetch_go = 1; drop_en = 1; drop_tid = 2'd0; step("R10");
    drop_tid = 2'd3; step("R10");
    drop_en = 0;
    for (int i = 0; i < 4; i++) step("R10");

    // R4 / R5: minimum occupancy with low-index tie break
    all_state('1, 0); policy = 2'd2;
    for (int i = 0; i < N; i++) iq[i] = 5;
    step("R4");
    iq[0] = 9; iq[1] = 3; iq[2] = 3; iq[3] = 7; step("R4");
    st[1] = 3; step("R4");
    policy = 2'd3;
    lsq[0] = 4; lsq[1] = 4; lsq[2] = 1; lsq[3] = 0; step("R5");
    st[3] = 4; step("R5");

    // R9: single thread mode only looks at the lowest active thread
    all_state(4'b1100, 0); policy = 2'd0;
    st[2] = 3; step("R9");
    st[2] = 1; step("R9");
    act_mask = 4'b0000; step("R9");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      if (n % 500 == 0) do_reset();
      act_mask = N'($urandom);
      for (int i = 0; i < N; i++) begin
        int r = $urandom % 12;
        st[i]  = (r < 8) ? r : ((r < 10) ? 0 : 5);
        iq[i]  = $urandom % 6;
        lsq[i] = $urandom % 6;
      end
      policy   = ($urandom % 2) ? 2'd1 : 2'($urandom);
      fetch_go = 1'($urandom);
      drop_en  = (($urandom % 10) == 0);
      drop_tid = TID_W'($urandom);
      case (policy)
        2'd0: step("R9");
        2'd1: step("R2");
        2'd2: step("R4");
        default: step("R5");
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule